// File: doc/BRIEF.md
# Clocked Multiplexed Address/Data Bus Slave with Ready Handshake

This block is the slave end of a synchronous host bus where one 16-bit path carries first an address and then a run of data words. The host owns the clock. It starts a transfer by pulling chip-enable and the address strobe low for one clock edge, with the target address on the low byte of the bus. It then releases the strobe, and the transfer continues as a burst of data beats until chip-enable goes high. The level of the write-enable pin at the address edge sets the direction of the burst.

A single ready output handles both directions. On reads it marks the cycles in which the slave drives a valid word. On writes it marks the cycles in which the slave takes the word on the bus. This lets the slave insert wait states.

Addresses below a fixed boundary select a small bank of host-visible registers, and the index advances with every beat. Addresses at or above the boundary select a stream. Reads pull from a receive queue that is filled on a valid/ready port. Writes push into a transmit queue that is emptied on a valid/ready port. The stream address never advances. When the receive queue is empty or the transmit queue is full, ready is held low. On a write the host must then hold its word.

Top module: `muxbus_slave`

## Requirements
- R1: Out of reset, rdy and ad_oe are 0, drain_valid is 0, fill_ready is 1, and every register reads as 0x0000.
- R2: A rising clock edge with ce_n=0 and adv_n=0 is an address phase. It latches ad_in[7:0] as the address and we_n as the direction (0 = write, 1 = read). In the cycle after an address phase rdy is 0, even if the edge interrupts a burst already in progress.
- R3: A read burst to an address a below 16 presents register a on ad_out with rdy=1 in the cycle after the next edge, so the host samples it on the second edge after the address edge. Each later edge with rdy=1 consumes the word and moves to register (index+1) mod 16.
- R4: A write burst to an address below 16 gives rdy=0 in its first data cycle and rdy=1 afterwards. Each edge with ce_n=0, adv_n=1, we_n=0 and rdy=1 stores ad_in into the current register and advances the index mod 16. Data cycles with we_n=1 store nothing.
- R5: A read burst to an address of 16 or more returns receive-queue words in arrival order. The address does not advance, and the register bank is not touched. rdy equals 1 exactly when the queue holds a word. A word is removed only by an edge that is a data beat while rdy=1.
- R6: A write burst to an address of 16 or more pushes accepted words into the 4-entry transmit queue in order, without touching the registers. After the turnaround cycle, rdy is 1 exactly when the queue has room once the current edge's push and drain are counted. A word offered while rdy=0 is not taken.
- R7: An edge with ce_n=1 ends the burst. In the next cycle rdy and ad_out enable are 0, and a word presented but not yet consumed stays at the head of its queue.
- R8: ad_oe is 1 only while ce_n=0, oe_n=0 and adv_n=1 during a read burst. It stays 0 during write bursts, whatever the level of oe_n.
- R9: fill_ready is 1 exactly when the receive queue holds fewer than 4 words. drain_valid is 1 exactly when the transmit queue is not empty, and while drain_ready=0 the head word holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write direction at the address edge, write strobe in data cycles, active low |
| oe_n | input | 1 | Output enable, active low |
| ad_in | input | 16 | Bus value as driven by the host |
| ad_out | output | 16 | Read word driven toward the bus |
| ad_oe | output | 1 | Enable for the bus drivers |
| rdy | output | 1 | Read word valid / write word accepted |
| fill_valid | input | 1 | Receive-queue source has a word |
| fill_data | input | 16 | Word for the receive queue |
| fill_ready | output | 1 | Receive queue can take a word |
| drain_valid | output | 1 | Transmit queue holds a word |
| drain_data | output | 16 | Head word of the transmit queue |
| drain_ready | input | 1 | Sink takes the head word |

## Verification
Register bursts are driven from every start index with a length of seventeen beats. This separates correct index wrap-around from a stall or an off-by-one in the first-word latency. Stream reads are started on an empty queue and fed part-way through. This shows whether rdy follows queue occupancy cycle by cycle rather than arriving at a fixed time. A burst cut short by chip-enable and then restarted shows whether a presented word is lost. Stream writes run once against a stalled sink, to show where back-pressure begins, and once against a free-running sink, to show that concurrent drain keeps ready high. Bursts with the write strobe high, bursts with output enable high, and addresses restarted mid-burst each show an input that must be ignored or must override.

// File: rtl/muxbus_pkg.sv
// Shared types for the multiplexed bus slave.
package muxbus_pkg;

    // Transfer phase of the bus port.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // no burst open
        PH_RD_LAT = 2'd1,   // read turnaround cycle after the address edge
        PH_RD     = 2'd2,   // read data beats
        PH_WR     = 2'd3    // write turnaround and data beats
    } bus_phase_e;

endpackage

// File: rtl/mbs_fifo.sv
// Show-ahead FIFO: head always presents the oldest word.
// Assumes DEPTH is a power of two of at least 2, push only when not full
// (or with a simultaneous pop), and pop only when not empty.
module mbs_fifo #(
    parameter  int WIDTH = 16,
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + PW'(1);
            if (pop)  rptr <= rptr + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Oldest entry is visible without a pop.
    always_comb begin
        head = mem[rptr];
    end

endmodule

// File: rtl/mbs_regbank.sv
// Bank of host-visible registers with one write port and one
// combinational read port. Assumes COUNT is a power of two.
module mbs_regbank #(
    parameter  int WIDTH = 16,
    parameter  int COUNT = 16,
    localparam int IW    = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] regs [COUNT];

    for (genvar i = 0; i < COUNT; i++) begin : g_reg
        // One register: cleared at reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    // Read select.
    always_comb begin
        rd_data = regs[rd_idx];
    end

endmodule

// File: rtl/mbs_phase_ctl.sv
// Bus phase sequencer: decodes address edges and data beats, keeps the
// register index, and computes the registered ready from the queue
// occupancy the next edge will leave. Assumes queue counts come from
// mbs_fifo instances of the given depths.
module mbs_phase_ctl
    import muxbus_pkg::*;
#(
    parameter  int ADDR_W    = 8,
    parameter  int REG_COUNT = 16,
    parameter  int RD_DEPTH  = 4,
    parameter  int WR_DEPTH  = 4,
    localparam int IW        = $clog2(REG_COUNT),
    localparam int RCW       = $clog2(RD_DEPTH) + 1,
    localparam int WCW       = $clog2(WR_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RCW-1:0]    rf_count,
    input  logic              rf_fill,
    input  logic [WCW-1:0]    wf_count,
    input  logic              wf_drain,
    output logic              rdy,
    output logic              ad_oe,
    output logic              to_fifo,
    output logic [IW-1:0]     idx,
    output logic              reg_wr,
    output logic              rf_pop,
    output logic              wf_push
);

    bus_phase_e phase;
    logic       beat;
    logic       addr_edge;
    logic       rd_take;
    logic       wr_take;
    logic [RCW:0] rf_next;
    logic [WCW:0] wf_next;
    logic       rf_has;
    logic       wf_room;

    // Beat classification and transfer strobes.
    always_comb begin
        beat      = !ce_n && adv_n;
        addr_edge = !ce_n && !adv_n;
        rd_take   = (phase == PH_RD) && beat && rdy;
        wr_take   = (phase == PH_WR) && beat && !we_n && rdy;
        rf_pop    = rd_take && to_fifo;
        wf_push   = wr_take && to_fifo;
        reg_wr    = wr_take && !to_fifo;
    end

    // Queue occupancy after the coming edge.
    always_comb begin
        rf_next = {1'b0, rf_count} + (RCW+1)'(rf_fill) - (RCW+1)'(rf_pop);
        wf_next = {1'b0, wf_count} + (WCW+1)'(wf_push) - (WCW+1)'(wf_drain);
        rf_has  = (rf_next != '0);
        wf_room = (wf_next < (WCW+1)'(WR_DEPTH));
    end

    // Drivers may turn on only in a read burst after the address phase.
    always_comb begin
        ad_oe = !ce_n && !oe_n && adv_n &&
                ((phase == PH_RD_LAT) || (phase == PH_RD));
    end

    // Phase, target, index and ready sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            rdy     <= 1'b0;
            to_fifo <= 1'b0;
            idx     <= '0;
        end else if (ce_n) begin
            phase <= PH_IDLE;
            rdy   <= 1'b0;
        end else if (addr_edge) begin
            phase   <= we_n ? PH_RD_LAT : PH_WR;
            rdy     <= 1'b0;
            to_fifo <= (addr >= ADDR_W'(REG_COUNT));
            idx     <= addr[IW-1:0];
        end else begin
            case (phase)
                PH_RD_LAT: begin
                    phase <= PH_RD;
                    rdy   <= to_fifo ? rf_has : 1'b1;
                end
                PH_RD: begin
                    if (rd_take && !to_fifo) idx <= idx + IW'(1);
                    rdy <= to_fifo ? rf_has : 1'b1;
                end
                PH_WR: begin
                    if (wr_take && !to_fifo) idx <= idx + IW'(1);
                    rdy <= to_fifo ? wf_room : 1'b1;
                end
                default: begin
                    rdy <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/muxbus_slave.sv
// Synchronous multiplexed address/data bus slave. Low addresses reach a
// register bank with an advancing index; high addresses stream through a
// receive queue (reads) or transmit queue (writes). Assumes the host
// holds write data while rdy is low and that ADDR_W <= DATA_W.
module muxbus_slave #(
    parameter  int DATA_W    = 16,
    parameter  int ADDR_W    = 8,
    parameter  int REG_COUNT = 16,
    parameter  int RD_DEPTH  = 4,
    parameter  int WR_DEPTH  = 4,
    localparam int IW        = $clog2(REG_COUNT),
    localparam int RCW       = $clog2(RD_DEPTH) + 1,
    localparam int WCW       = $clog2(WR_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rdy,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fill_ready,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data,
    input  logic              drain_ready
);

    logic [RCW-1:0]    rf_count;
    logic [WCW-1:0]    wf_count;
    logic [DATA_W-1:0] rf_head;
    logic [DATA_W-1:0] reg_rd;
    logic              rf_fill;
    logic              wf_drain;
    logic              rf_pop;
    logic              wf_push;
    logic              reg_wr;
    logic              to_fifo;
    logic [IW-1:0]     idx;

    // Queue-side handshakes.
    always_comb begin
        fill_ready  = (rf_count < RCW'(RD_DEPTH));
        rf_fill     = fill_valid && fill_ready;
        drain_valid = (wf_count != '0);
        wf_drain    = drain_valid && drain_ready;
    end

    mbs_phase_ctl #(
        .ADDR_W   (ADDR_W),
        .REG_COUNT(REG_COUNT),
        .RD_DEPTH (RD_DEPTH),
        .WR_DEPTH (WR_DEPTH)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .adv_n   (adv_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (ad_in[ADDR_W-1:0]),
        .rf_count(rf_count),
        .rf_fill (rf_fill),
        .wf_count(wf_count),
        .wf_drain(wf_drain),
        .rdy     (rdy),
        .ad_oe   (ad_oe),
        .to_fifo (to_fifo),
        .idx     (idx),
        .reg_wr  (reg_wr),
        .rf_pop  (rf_pop),
        .wf_push (wf_push)
    );

    mbs_regbank #(
        .WIDTH(DATA_W),
        .COUNT(REG_COUNT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_idx (idx),
        .wr_data(ad_in),
        .rd_idx (idx),
        .rd_data(reg_rd)
    );

    mbs_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(RD_DEPTH)
    ) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rf_fill),
        .push_data(fill_data),
        .pop      (rf_pop),
        .head     (rf_head),
        .count    (rf_count)
    );

    mbs_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(WR_DEPTH)
    ) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wf_push),
        .push_data(ad_in),
        .pop      (wf_drain),
        .head     (drain_data),
        .count    (wf_count)
    );

    // Read word source follows the decoded target.
    always_comb begin
        ad_out = to_fifo ? rf_head : reg_rd;
    end

endmodule

// File: rtl/muxbus_slave_chk.sv
// Protocol checker for muxbus_slave, attached by bind below.
// Assumes the internal transmit-queue count is named wf_count.
module muxbus_slave_chk #(
    parameter  int DATA_W   = 16,
    parameter  int WR_DEPTH = 4,
    localparam int WCW      = $clog2(WR_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              rdy,
    input logic              ad_oe,
    input logic              drain_valid,
    input logic              drain_ready,
    input logic [DATA_W-1:0] drain_data,
    input logic [WCW-1:0]    wf_count
);

    // R8
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!ce_n && !oe_n && adv_n));

    // R7
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !rdy);

    // R2
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) |=> !rdy);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wf_count <= WCW'(WR_DEPTH));

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_data)));

endmodule

bind muxbus_slave muxbus_slave_chk #(
    .DATA_W  (DATA_W),
    .WR_DEPTH(WR_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .rdy        (rdy),
    .ad_oe      (ad_oe),
    .drain_valid(drain_valid),
    .drain_ready(drain_ready),
    .drain_data (drain_data),
    .wf_count   (wf_count)
);

// File: tb/muxbus_slave_bench.sv
`timescale 1ns/1ps
module muxbus_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe, rdy;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_data = '0;
    logic        fill_ready;
    logic        drain_valid;
    logic [15:0] drain_data;
    logic        drain_ready = 1'b0;

    int vectors = 0;
    int fails = 0;
    logic [15:0] mreg [16];
    logic [15:0] rq[$];
    logic [15:0] wq[$];

    muxbus_slave u_muxbus_slave (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rdy(rdy),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
        .drain_valid(drain_valid), .drain_data(drain_data), .drain_ready(drain_ready)
    );

    initial forever #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input int seed);
        return 16'((i * 16'h1357) ^ (seed * 16'h0F0F) ^ 16'h5A00);
    endfunction

    // Address phase; returns at negedge+1 of the cycle after the address edge.
    task automatic bus_addr(input logic [7:0] a, input bit wr);
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; we_n = !wr; oe_n = wr; ad_in = {8'h00, a};
        @(negedge clk);
        adv_n = 1'b1;
        #1;
        chk("R2 rdy after address", rdy, 0);
        if (!wr) chk("R8 drive in read turnaround", ad_oe, 1);
    endtask

    // Raise chip enable before the coming edge and check the idle cycle.
    task automatic bus_end();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); #1;
        chk("R7 rdy after burst end", rdy, 0);
        chk("R7 R8 drive after burst end", ad_oe, 0);
    endtask

    task automatic reg_read(input int s, input int len);
        bus_addr(8'(s), 1'b0);
        for (int j = 0; j < len; j++) begin
            @(negedge clk); #1;
            chk("R3 rdy in register read", rdy, 1);
            chk("R3 register word", ad_out, mreg[(s + j) % 16]);
        end
        bus_end();
    endtask

    task automatic reg_write(input int s, input int len, input int seed);
        int j = 0;
        int waits = 0;
        bus_addr(8'(s), 1'b1);
        while (j < len && waits < 50) begin
            ad_in = pat(j, seed);
            if (rdy) begin
                mreg[(s + j) % 16] = ad_in;
                j++;
            end else begin
                waits++;
            end
            @(negedge clk); #1;
        end
        bus_end();
        chk("R4 single turnaround wait", waits, 1);
    endtask

    task automatic fifo_read(input logic [7:0] a, input int ncyc, input int nfill, input int fstart);
        int k = 0;
        bus_addr(a, 1'b0);
        for (int c = 0; c < ncyc; c++) begin
            bit last;
            bit fv;
            last = (c == ncyc - 1);
            @(negedge clk); #1;
            chk("R5 rdy follows queue", rdy, (rq.size() > 0));
            chk("R9 fill_ready", fill_ready, (rq.size() < 4));
            if (rdy) chk("R5 stream word order", ad_out, rq[0]);
            fv = !last && (c >= fstart) && (k < nfill);
            fill_valid = fv;
            fill_data = 16'hB000 + 16'(k);
            if (rdy && !last) void'(rq.pop_front());
            if (fv && fill_ready) begin
                rq.push_back(fill_data);
                k++;
            end
        end
        fill_valid = 1'b0;
        bus_end();
    endtask

    task automatic fill_idle(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            chk("R9 fill_ready while idle", fill_ready, (rq.size() < 4));
            fill_valid = 1'b1;
            fill_data = base + 16'(i);
            if (fill_ready) rq.push_back(fill_data);
            @(negedge clk); #1;
        end
        fill_valid = 1'b0;
    endtask

    task automatic fifo_write(input logic [7:0] a, input int nw, input int ncyc,
                              input bit dr, output int n);
        bit first = 1'b1;
        n = 0;
        bus_addr(a, 1'b1);
        oe_n = 1'b0;
        drain_ready = dr;
        for (int c = 0; c < ncyc; c++) begin
            if (n == nw) break;
            ad_in = 16'hC000 + 16'(n * 7) + {8'h00, a};
            chk("R6 write rdy", rdy, first ? 1'b0 : (wq.size() < 4));
            chk("R8 no drive in write", ad_oe, 0);
            chk("R9 drain_valid", drain_valid, (wq.size() > 0));
            if (drain_valid && dr) begin
                chk("R6 drain order", drain_data, wq[0]);
                void'(wq.pop_front());
            end
            if (rdy) begin
                wq.push_back(ad_in);
                n++;
            end
            first = 1'b0;
            @(negedge clk); #1;
        end
        drain_ready = 1'b0;
        bus_end();
    endtask

    task automatic drain_all(input int ncyc);
        drain_ready = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            chk("R9 drain_valid", drain_valid, (wq.size() > 0));
            if (drain_valid) begin
                chk("R6 drain order", drain_data, wq[0]);
                void'(wq.pop_front());
            end
            @(negedge clk); #1;
        end
        drain_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 16; i++) mreg[i] = 16'h0000;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 rdy in reset", rdy, 0);
        chk("R1 drive in reset", ad_oe, 0);
        chk("R1 drain_valid in reset", drain_valid, 0);
        chk("R1 fill_ready in reset", fill_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 registers clear, R3 sweep of reads
        reg_read(0, 16);
        reg_write(0, 16, 1);
        for (int s = 0; s < 16; s++) reg_read(s, 17);
        reg_write(13, 5, 2);
        reg_read(0, 16);

        // R8 output enable high: word presented, drivers off
        bus_addr(8'd3, 1'b0);
        oe_n = 1'b1;
        @(negedge clk); #1;
        chk("R8 drive with oe_n high", ad_oe, 0);
        chk("R3 word with oe_n high", ad_out, mreg[3]);
        bus_end();

        // R2 new address mid-burst overrides
        bus_addr(8'd5, 1'b0);
        @(negedge clk); #1;
        chk("R3 first word", ad_out, mreg[5]);
        bus_addr(8'd9, 1'b0);
        @(negedge clk); #1;
        chk("R2 restarted word", ad_out, mreg[9]);
        bus_end();

        // R4 we_n high in data cycles stores nothing
        bus_addr(8'd2, 1'b1);
        we_n = 1'b1;
        ad_in = 16'hDEAD;
        repeat (3) @(negedge clk);
        #1;
        bus_end();
        reg_read(2, 1);

        // R5 empty queue then late fill
        fifo_read(8'h90, 12, 3, 4);
        // R7 unconsumed word survives a burst end
        fill_idle(2, 16'hE100);
        fifo_read(8'h91, 1, 0, 0);
        fifo_read(8'hA0, 4, 0, 0);
        // R9 fill beyond capacity
        fill_idle(6, 16'hE200);
        fifo_read(8'hFF, 7, 0, 0);

        // R6 back-pressure with a stalled sink, then free-running sink
        fifo_write(8'hF0, 6, 8, 1'b0, n);
        chk("R6 words taken before full", n, 4);
        drain_all(6);
        fifo_write(8'hF3, 6, 20, 1'b1, n);
        chk("R6 words taken with drain", n, 6);
        drain_all(6);

        // R5 R6 stream accesses left registers intact
        reg_read(0, 16);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule